// File: doc/BRIEF.md
# Indexed Colour Palette Port Controller

This block holds a 256-entry colour table and gives a processor access to it through four byte-wide I/O ports. Each table entry is three 6-bit components stored in the order red, green, blue. Software sets a write pointer, then sends three data bytes per entry. Software can also set a separate read pointer and fetch the entry back one component at a time. Both pointers advance by themselves after every third byte. One component counter is shared by the read and write paths.

A second path converts a 4-bit text colour code into a 24-bit colour for display. The code selects one of sixteen 6-bit attribute palette values, which arrive as inputs. That value is combined with a 4-bit colour-select input to form the table index. The selected entry is widened to 8 bits per component, and the result is registered.

Top module: `dacPortTop`

## Requirements
- R1: While reset is asserted, `ioRData` and `lookColour` are 0. After reset, the write index, read index, component counter and state readback are all 0. Palette contents are undefined.
- R2: A write to selector 0 loads the write index from `ioWData`, clears the component counter and sets the state readback to 0. A read of selector 0 returns the current write index.
- R3: A write to selector 1 loads the read index, clears the component counter and sets the state readback to 3. A read of selector 1 returns the state readback, which is 0 or 3.
- R4: Data bytes written to selector 2 are held in a buffer and do not change the table before the third byte. On the third byte, all three components are stored at the write index in the order they arrived, the counter returns to 0 and the write index increments.
- R5: A read of selector 2 returns `{2'b00, component}` of the entry at the read index. Component 0 is red, 1 is green and 2 is blue, chosen by the counter. After component 2, the counter returns to 0 and the read index increments.
- R6: The component counter is shared. A data read that follows a data write of one byte returns component 1.
- R7: Both indices are 8 bits wide and wrap from 255 to 0.
- R8: Each 6-bit component v is widened to `{v, v[0], v[0]}`. `lookColour` is `{red8, green8, blue8}`.
- R9: When `attrModeHi` is 1, the table index is `{colourSel[3:0], attrPal[textIdx][3:0]}`.
- R10: When `attrModeHi` is 0, the table index is `{colourSel[3:2], attrPal[textIdx][5:0]}`. Attribute value i occupies `attrPalFlat[6*i +: 6]`.
- R11: `lookColour` follows the lookup inputs one clock later, with no combinational path. A table write that commits on an edge first becomes visible at the next edge.
- R12: Selector 3 reads as 0, and writes to it change nothing. If `ioWrEn` and `ioRdEn` are both high, only the write acts and `ioRData` holds its value.
- R13: Bits 7:6 of data bytes are dropped.
- R14: The result of a read appears on `ioRData` after the clock edge that samples `ioRdEn`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | Byte write strobe |
| ioRdEn | input | 1 | Byte read strobe |
| ioSel | input | 2 | Port selector: 0 write index, 1 read index/state, 2 data, 3 unused |
| ioWData | input | 8 | Write data |
| ioRData | output | 8 | Registered read data |
| attrPalFlat | input | 96 | Sixteen 6-bit attribute palette values |
| attrModeHi | input | 1 | Index formation mode |
| colourSel | input | 4 | Colour-select bits |
| textIdx | input | 4 | Text colour code to look up |
| lookColour | output | 24 | Widened colour, one cycle after the lookup inputs |

## Verification
The checker watches the control state on every cycle. It confirms that the pointer loads and state values follow a port write, and that the write index moves only on a commit byte. It also confirms that the counter never reaches 3, that a third data read advances the read index, and that selector 3 writes leave all state unchanged. Some behaviour is visible only through the table contents, so only the bench scenarios can show it. This covers the buffering of the first two bytes, the component order and shared counter seen through data reads, the widening, both index modes, and the one-edge delay between a commit and its appearance on the lookup path. These scenarios are compared against a behavioural model on every clock.

// File: rtl/dacPortPkg.sv
`timescale 1ns/1ps
package dacPortPkg;
  localparam int unsigned IDX_W    = 8;
  localparam int unsigned COMP_W   = 6;
  localparam int unsigned NCOMP    = 3;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned OUT_W    = 8;
  localparam int unsigned ATTR_N   = 16;
  localparam int unsigned TXT_W    = $clog2(ATTR_N);
  localparam int unsigned ENTRY_W  = COMP_W * NCOMP;
  localparam int unsigned COLOUR_W = OUT_W * NCOMP;
  localparam int unsigned DEPTH    = 1 << IDX_W;
  localparam logic [1:0]  STATE_RD = 2'd3;
  localparam logic [1:0]  STATE_WR = 2'd0;

  typedef enum logic [1:0] {
    SEL_WIDX = 2'd0,
    SEL_RIDX = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } portSel_e;

  typedef enum logic [1:0] {
    RB_WIDX  = 2'd0,
    RB_STATE = 2'd1,
    RB_DATA  = 2'd2,
    RB_ZERO  = 2'd3
  } rbSel_e;

  typedef struct packed {
    logic             capEn;
    logic             commitEn;
    logic             rbEn;
    rbSel_e           rbSel;
    logic [1:0]       slot;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
    logic [1:0]       state;
  } dacStrb_t;
endpackage

// File: rtl/dacPortCtrl.sv
`timescale 1ns/1ps
module dacPortCtrl
  import dacPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [1:0]        ioSel,
  input  logic [BYTE_W-1:0] ioWData,
  output dacStrb_t          strb
);
  localparam logic [1:0] LAST_SLOT = 2'(NCOMP - 1);

  logic [IDX_W-1:0] wrIdxQ, rdIdxQ;
  logic [1:0]       subQ, stateQ;
  logic             doWr, doRd, lastSlot;
  portSel_e         selE;

  assign selE     = portSel_e'(ioSel);
  assign doWr     = ioWrEn;
  assign doRd     = ioRdEn & ~ioWrEn;
  assign lastSlot = (subQ == LAST_SLOT);

  always_comb begin
    strb          = '0;
    strb.capEn    = doWr && (selE == SEL_DATA);
    strb.commitEn = doWr && (selE == SEL_DATA) && lastSlot;
    strb.rbEn     = doRd;
    strb.slot     = subQ;
    strb.wrIdx    = wrIdxQ;
    strb.rdIdx    = rdIdxQ;
    strb.state    = stateQ;
    unique case (selE)
      SEL_WIDX: strb.rbSel = RB_WIDX;
      SEL_RIDX: strb.rbSel = RB_STATE;
      SEL_DATA: strb.rbSel = RB_DATA;
      default:  strb.rbSel = RB_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdxQ <= '0;
      rdIdxQ <= '0;
      subQ   <= '0;
      stateQ <= STATE_WR;
    end else if (doWr) begin
      unique case (selE)
        SEL_WIDX: begin
          wrIdxQ <= ioWData[IDX_W-1:0];
          subQ   <= '0;
          stateQ <= STATE_WR;
        end
        SEL_RIDX: begin
          rdIdxQ <= ioWData[IDX_W-1:0];
          subQ   <= '0;
          stateQ <= STATE_RD;
        end
        SEL_DATA: begin
          if (lastSlot) begin
            subQ   <= '0;
            wrIdxQ <= wrIdxQ + IDX_W'(1);
          end else begin
            subQ <= subQ + 2'd1;
          end
        end
        default: ;
      endcase
    end else if (doRd && selE == SEL_DATA) begin
      if (lastSlot) begin
        subQ   <= '0;
        rdIdxQ <= rdIdxQ + IDX_W'(1);
      end else begin
        subQ <= subQ + 2'd1;
      end
    end
  end
endmodule

// File: rtl/dacPortDatapath.sv
`timescale 1ns/1ps
module dacPortDatapath
  import dacPortPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dacStrb_t           strb,
  input  logic [COMP_W-1:0]  wrComp,
  input  logic [IDX_W-1:0]   lookIdx,
  output logic [ENTRY_W-1:0] lookEntry,
  output logic [BYTE_W-1:0]  ioRData
);
  logic [ENTRY_W-1:0] palMem [DEPTH];
  logic [COMP_W-1:0]  cache0Q, cache1Q;
  logic [ENTRY_W-1:0] rdEntry;
  logic [COMP_W-1:0]  compArr [NCOMP];
  logic [COMP_W-1:0]  rdComp;
  logic [BYTE_W-1:0]  rbNext;

  always_ff @(posedge clk) begin
    if (strb.commitEn) palMem[strb.wrIdx] <= {cache0Q, cache1Q, wrComp};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cache0Q <= '0;
      cache1Q <= '0;
    end else if (strb.capEn && !strb.commitEn) begin
      if (strb.slot == 2'd0) cache0Q <= wrComp;
      else                   cache1Q <= wrComp;
    end
  end

  assign rdEntry   = palMem[strb.rdIdx];
  assign lookEntry = palMem[lookIdx];

  for (genvar g = 0; g < NCOMP; g++) begin : g_split
    assign compArr[g] = rdEntry[(NCOMP-1-g)*COMP_W +: COMP_W];
  end

  always_comb begin
    case (strb.slot)
      2'd0:    rdComp = compArr[0];
      2'd1:    rdComp = compArr[1];
      default: rdComp = compArr[2];
    endcase
  end

  always_comb begin
    unique case (strb.rbSel)
      RB_WIDX:  rbNext = BYTE_W'(strb.wrIdx);
      RB_STATE: rbNext = BYTE_W'(strb.state);
      RB_DATA:  rbNext = BYTE_W'(rdComp);
      default:  rbNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          ioRData <= '0;
    else if (strb.rbEn) ioRData <= rbNext;
  end
endmodule

// File: rtl/dacLookup.sv
`timescale 1ns/1ps
module dacLookup
  import dacPortPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ATTR_N*COMP_W-1:0] attrPalFlat,
  input  logic                     attrModeHi,
  input  logic [3:0]               colourSel,
  input  logic [TXT_W-1:0]         textIdx,
  output logic [IDX_W-1:0]         lookIdx,
  input  logic [ENTRY_W-1:0]       lookEntry,
  output logic [COLOUR_W-1:0]      lookColour
);
  logic [COMP_W-1:0]   attrArr [ATTR_N];
  logic [COMP_W-1:0]   attrVal;
  logic [COLOUR_W-1:0] colourNext;

  for (genvar i = 0; i < ATTR_N; i++) begin : g_attr
    assign attrArr[i] = attrPalFlat[i*COMP_W +: COMP_W];
  end

  assign attrVal = attrArr[textIdx];
  assign lookIdx = attrModeHi ? {colourSel[3:0], attrVal[3:0]}
                              : {colourSel[3:2], attrVal[5:0]};

  for (genvar g = 0; g < NCOMP; g++) begin : g_widen
    logic [COMP_W-1:0] c;
    assign c = lookEntry[(NCOMP-1-g)*COMP_W +: COMP_W];
    assign colourNext[(NCOMP-1-g)*OUT_W +: OUT_W] = {c, c[0], c[0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) lookColour <= '0;
    else       lookColour <= colourNext;
  end
endmodule

// File: rtl/dacPortTop.sv
`timescale 1ns/1ps
module dacPortTop
  import dacPortPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioWrEn,
  input  logic        ioRdEn,
  input  logic [1:0]  ioSel,
  input  logic [7:0]  ioWData,
  output logic [7:0]  ioRData,
  input  logic [95:0] attrPalFlat,
  input  logic        attrModeHi,
  input  logic [3:0]  colourSel,
  input  logic [3:0]  textIdx,
  output logic [23:0] lookColour
);
  dacStrb_t           ctlStrb;
  logic [IDX_W-1:0]   lookIdx;
  logic [ENTRY_W-1:0] lookEntry;

  dacPortCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioSel(ioSel), .ioWData(ioWData), .strb(ctlStrb)
  );

  dacPortDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(ctlStrb), .wrComp(ioWData[COMP_W-1:0]),
    .lookIdx(lookIdx), .lookEntry(lookEntry), .ioRData(ioRData)
  );

  dacLookup u_look (
    .clk(clk), .rstN(rstN), .attrPalFlat(attrPalFlat), .attrModeHi(attrModeHi),
    .colourSel(colourSel), .textIdx(textIdx), .lookIdx(lookIdx),
    .lookEntry(lookEntry), .lookColour(lookColour)
  );
endmodule

// File: rtl/dacPortChk.sv
`timescale 1ns/1ps
module dacPortChk
  import dacPortPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       ioWrEn,
  input logic       ioRdEn,
  input logic [1:0] ioSel,
  input logic [7:0] ioWData,
  input dacStrb_t   strb
);
  assert_widx_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioSel == 2'd0) |=> (strb.wrIdx == $past(ioWData) && strb.slot == 2'd0 && strb.state == 2'd0));

  assert_ridx_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioSel == 2'd1) |=> (strb.rdIdx == $past(ioWData) && strb.slot == 2'd0 && strb.state == 2'd3));

  assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.state == 2'd0 || strb.state == 2'd3));

  assert_hold_widx_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioSel == 2'd2 && strb.slot != 2'd2) |=> $stable(strb.wrIdx));

  assert_commit_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioSel == 2'd2 && strb.slot == 2'd2) |=> (strb.wrIdx == 8'($past(strb.wrIdx) + 8'd1) && strb.slot == 2'd0));

  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdEn && !ioWrEn && ioSel == 2'd2 && strb.slot == 2'd2) |=> (strb.rdIdx == 8'($past(strb.rdIdx) + 8'd1) && strb.slot == 2'd0));

  assert_slot_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.slot != 2'd3);

  assert_unused_sel_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioSel == 2'd3) |=> ($stable(strb.wrIdx) && $stable(strb.rdIdx) && $stable(strb.slot) && $stable(strb.state)));
endmodule

bind dacPortTop dacPortChk u_chk (
  .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
  .ioSel(ioSel), .ioWData(ioWData), .strb(ctlStrb)
);

// File: tb/dacPortTop_tb.sv
`timescale 1ns/1ps
module dacPortTop_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [1:0]  ioSel = 2'd0;
  logic [7:0]  ioWData = 8'd0;
  logic [7:0]  ioRData;
  logic [95:0] attrPalFlat = '0;
  logic        attrModeHi = 1'b1;
  logic [3:0]  colourSel = 4'd0;
  logic [3:0]  textIdx = 4'd0;
  logic [23:0] lookColour;

  int tests = 0, fails = 0;
  bit cmpOn = 0, palReady = 0, finished = 0;

  // behavioural reference
  int mPal [256][3];
  int mCache [3];
  int mWi, mRi, mSub, mState, mRd, mLook;

  always #2.5 clk = ~clk;

  dacPortTop u_dut (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioSel(ioSel),
    .ioWData(ioWData), .ioRData(ioRData), .attrPalFlat(attrPalFlat),
    .attrModeHi(attrModeHi), .colourSel(colourSel), .textIdx(textIdx),
    .lookColour(lookColour)
  );

  function automatic int widen(int v);
    return (v * 4) + ((v % 2) * 3);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mWi = 0; mRi = 0; mSub = 0; mState = 0; mRd = 0; mLook = 0;
    end else begin
      int a, ix;
      a = int'(attrPalFlat[textIdx*6 +: 6]);
      if (attrModeHi) ix = int'(colourSel) * 16 + (a % 16);
      else            ix = int'(colourSel[3:2]) * 64 + a;
      mLook = widen(mPal[ix][0]) * 65536 + widen(mPal[ix][1]) * 256 + widen(mPal[ix][2]);
      if (ioWrEn) begin
        case (ioSel)
          2'd0: begin mWi = int'(ioWData); mSub = 0; mState = 0; end
          2'd1: begin mRi = int'(ioWData); mSub = 0; mState = 3; end
          2'd2: begin
            mCache[mSub] = int'(ioWData) % 64;
            if (mSub == 2) begin
              for (int c = 0; c < 3; c++) mPal[mWi][c] = mCache[c];
              mSub = 0; mWi = (mWi + 1) % 256;
            end else mSub++;
          end
          default: ;
        endcase
      end else if (ioRdEn) begin
        case (ioSel)
          2'd0: mRd = mWi;
          2'd1: mRd = mState;
          2'd2: begin
            mRd = mPal[mRi][mSub];
            if (mSub == 2) begin mSub = 0; mRi = (mRi + 1) % 256; end
            else mSub++;
          end
          default: mRd = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      tests++;
      if (int'(ioRData) !== mRd) begin
        fails++;
        $display("FAIL R14 model ioRData act=%h exp=%h", ioRData, mRd[7:0]);
      end
      if (palReady) begin
        tests++;
        if (int'(lookColour) !== mLook) begin
          fails++;
          $display("FAIL R11 model lookColour act=%h exp=%h", lookColour, mLook[23:0]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit wr, input bit rd, input logic [1:0] sel, input logic [7:0] d);
    ioWrEn = wr; ioRdEn = rd; ioSel = sel; ioWData = d;
    @(negedge clk);
    ioWrEn = 0; ioRdEn = 0;
  endtask

  task automatic rdPort(input logic [1:0] sel, output logic [7:0] v);
    op(0, 1, sel, 8'd0);
    v = ioRData;
  endtask

  function automatic logic [7:0] pat(int e, int c);
    return 8'((e * 3 + c * 7) % 64);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 reset ioRData", 32'(ioRData), 32'h0);
    chk("R1 reset lookColour", 32'(lookColour), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1;
    rdPort(2'd0, v); chk("R1 write index after reset", 32'(v), 32'h0);
    rdPort(2'd1, v); chk("R1 state after reset", 32'(v), 32'h0);

    // fill whole table, with top bits set (R13)
    op(1, 0, 2'd0, 8'd0);
    for (int e = 0; e < 256; e++)
      for (int c = 0; c < 3; c++) op(1, 0, 2'd2, 8'hC0 | pat(e, c));
    rdPort(2'd0, v); chk("R7 write index wrapped after 256 entries", 32'(v), 32'h0);
    palReady = 1;

    // R3 / R5 / R13
    op(1, 0, 2'd1, 8'd5);
    rdPort(2'd1, v); chk("R3 state after read-index load", 32'(v), 32'd3);
    for (int c = 0; c < 3; c++) begin
      rdPort(2'd2, v); chk("R5 R13 data read", 32'(v), 32'(pat(5, c)));
    end
    rdPort(2'd2, v); chk("R5 read index advanced", 32'(v), 32'(pat(6, 0)));

    // R2
    op(1, 0, 2'd0, 8'h40);
    rdPort(2'd0, v); chk("R2 write index readback", 32'(v), 32'h40);
    rdPort(2'd1, v); chk("R2 state after write-index load", 32'(v), 32'h0);

    // R6 shared counter, R4 not yet committed
    op(1, 0, 2'd1, 8'd10);
    op(1, 0, 2'd0, 8'd10);
    op(1, 0, 2'd2, 8'h11);
    rdPort(2'd2, v); chk("R6 R4 read after one write byte", 32'(v), 32'(pat(10, 1)));

    // R4 via lookup: entry 10 through mode hi, colourSel 0, attr 0 = 10
    attrPalFlat[0 +: 6] = 6'd10; attrModeHi = 1; colourSel = 4'd0; textIdx = 4'd0;
    op(1, 0, 2'd0, 8'd10);
    op(1, 0, 2'd2, 8'h22);
    op(1, 0, 2'd2, 8'h33);
    @(negedge clk);
    chk("R4 entry unchanged after two bytes", 32'(lookColour), 32'h7897B0);
    op(1, 0, 2'd2, 8'h2A);
    @(negedge clk);
    chk("R4 R8 entry after commit", 32'(lookColour), 32'h88CFA8);
    rdPort(2'd0, v); chk("R4 write index incremented", 32'(v), 32'd11);
    op(1, 0, 2'd1, 8'd10);
    rdPort(2'd2, v); chk("R4 committed red", 32'(v), 32'h22);
    rdPort(2'd2, v); chk("R4 committed green", 32'(v), 32'h33);
    rdPort(2'd2, v); chk("R4 committed blue", 32'(v), 32'h2A);

    // R7 wrap of both indices
    op(1, 0, 2'd0, 8'd255);
    op(1, 0, 2'd2, 8'd1); op(1, 0, 2'd2, 8'd2); op(1, 0, 2'd2, 8'd3);
    rdPort(2'd0, v); chk("R7 write index wrap", 32'(v), 32'h0);
    op(1, 0, 2'd1, 8'd255);
    for (int c = 0; c < 3; c++) begin
      rdPort(2'd2, v); chk("R7 entry 255", 32'(v), 32'(c + 1));
    end
    rdPort(2'd2, v); chk("R7 read index wrap", 32'(v), 32'(pat(0, 0)));

    // R8 R9 R10 lookup
    op(1, 0, 2'd0, 8'd5);
    op(1, 0, 2'd2, 8'h3F); op(1, 0, 2'd2, 8'h01); op(1, 0, 2'd2, 8'h20);
    attrPalFlat[3*6 +: 6] = 6'h05; colourSel = 4'h0; attrModeHi = 1; textIdx = 4'd3;
    @(negedge clk);
    chk("R8 R9 widened colour", 32'(lookColour), 32'hFF0780);
    op(1, 0, 2'd0, 8'hB5);
    op(1, 0, 2'd2, 8'd1); op(1, 0, 2'd2, 8'd2); op(1, 0, 2'd2, 8'd3);
    op(1, 0, 2'd0, 8'hA5);
    op(1, 0, 2'd2, 8'h10); op(1, 0, 2'd2, 8'h20); op(1, 0, 2'd2, 8'h30);
    attrPalFlat[7*6 +: 6] = 6'h25; colourSel = 4'hB; textIdx = 4'd7;
    @(negedge clk);
    chk("R9 mode hi index", 32'(lookColour), 32'h07080F);
    attrModeHi = 0;
    @(negedge clk);
    chk("R10 mode lo index", 32'(lookColour), 32'h4080C0);

    // R11 latency
    attrModeHi = 1;
    @(negedge clk);
    op(1, 0, 2'd0, 8'hB5);
    op(1, 0, 2'd2, 8'd3); op(1, 0, 2'd2, 8'd3);
    op(1, 0, 2'd2, 8'd3);
    chk("R11 commit not visible on same edge", 32'(lookColour), 32'h07080F);
    @(negedge clk);
    chk("R11 commit visible next edge", 32'(lookColour), 32'h0F0F0F);
    textIdx = 4'd0;
    #0.1;
    chk("R11 no combinational path", 32'(lookColour), 32'h0F0F0F);
    @(negedge clk);
    chk("R11 one clock latency", 32'(lookColour), 32'hB8D7F0);

    // R12
    op(1, 0, 2'd3, 8'hFF);
    rdPort(2'd0, v); chk("R12 unused write ignored", 32'(v), 32'hB6);
    rdPort(2'd3, v); chk("R12 unused reads zero", 32'(v), 32'h0);
    op(1, 1, 2'd0, 8'h77);
    chk("R12 R14 read suppressed by write", 32'(ioRData), 32'h0);
    rdPort(2'd0, v); chk("R12 simultaneous write applied", 32'(v), 32'h77);
    repeat (3) @(negedge clk);
    chk("R14 read data holds", 32'(ioRData), 32'h77);

    summary();
  end
endmodule